// File: doc/BRIEF.md
# Multi-Mode PWM Channel Generator

This block drives one PWM output pin from a phase counter that advances on a divided clock. The counter's step size comes from a resolution setting, so one PWM period spans `2^(resn+1)` counter ticks. The channel compares the top `resn+1` bits of the phase against the top bits of a duty value and drives the pin high while the phase is below the duty.

The duty value comes from one of three modes:
- **Pulse mode** holds duty A.
- **Blink mode** shows A for a set number of periods, then B for a set number of periods, and repeats.
- **Heartbeat mode** walks the duty from A toward B in fixed increments, then back toward A, and repeats.

Each channel also has a phase offset, an output polarity inversion and an enable. The configuration is held in internal registers. It is loaded by a write strobe, and the block accepts a write only while both the counter and the channel are stopped.

Top module: `pwm_chan_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, `pwm_o` becomes 0 and every configuration register clears to 0.
- R2: With `cntr_en` high, the phase advances by `2^(15-resn)` once every `clk_div+1` clocks. A PWM period therefore lasts `(clk_div+1)*2^(resn+1)` clocks. With `cntr_en` low, the phase is held at 0.
- R3: One clock after an edge, `pwm_o` is high exactly when the top `resn+1` bits of `(phase + phase_off)` mod 2^16 are below the top `resn+1` bits of the current duty. The high count per period therefore equals the duty's top bits.
- R4: With `blink_on` = 0, every period uses duty A and B has no effect.
- R5: With `blink_on` = 1 and `beat_on` = 0, the channel shows A for `cnt_x+1` periods, then B for `cnt_y+1` periods, and repeats. This holds for A greater than, less than or equal to B.
- R6: With `blink_on` = 1 and `beat_on` = 1, the duty starts at A. Every `cnt_x+1` periods it moves toward the current target (first B, then A, alternating) by `cnt_y+1`. When it reaches or passes the target it is clamped to the target and the direction reverses. This works for either ordering of A and B, and A equal to B gives a constant duty.
- R7: The heartbeat step never wraps. A step past 0xFFFF saturates at 0xFFFF, a step below 0 saturates at 0, and both are then clamped to the target.
- R8: `phase_off` is added to the shared phase before the compare, which shifts the high window earlier within the period.
- R9: `invert` = 1 inverts `pwm_o` relative to R3.
- R10: One clock after `ch_en` is sampled low, `pwm_o` equals `invert`. The mode sequencing is returned to its start, so on re-enable the channel begins again at duty A with fresh hold counts.
- R11: A `cfg_wr` pulse loads the `cfg_*` inputs only when `cntr_en` and `ch_en` are both low. Otherwise the stored configuration is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cntr_en | input | 1 | Runs the phase counter |
| ch_en | input | 1 | Enables the channel |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_clk_div | input | DIV_W | Clock divider: counter ticks every clk_div+1 clocks |
| cfg_resn | input | $clog2(CNT_W) | Resolution: compare width minus one |
| cfg_duty_a | input | CNT_W | Duty value A |
| cfg_duty_b | input | CNT_W | Duty value B |
| cfg_cnt_x | input | CNT_W | Periods per hold, minus one |
| cfg_cnt_y | input | CNT_W | Blink B hold length minus one, or heartbeat step minus one |
| cfg_blink | input | 1 | Selects a sequenced mode |
| cfg_beat | input | 1 | Selects heartbeat when sequenced |
| cfg_phase | input | CNT_W | Phase offset added before the compare |
| cfg_invert | input | 1 | Output polarity inversion |
| pwm_o | output | 1 | PWM pin level |

## Verification
On every cycle, the assertions check four properties:
- the configuration lock;
- the zero phase of a stopped counter;
- the idle pin level of a disabled channel;
- that the live duty stays within its mode's legal set (A only in pulse mode, A or B in blink mode, between A and B in heartbeat mode).

Some behaviour is visible only to the bench's scenarios, which count high clocks per period at the pin. These are:
- the exact per-period high counts;
- the ordering of the blink and heartbeat sequences;
- saturation at both ends of the duty range;
- the position of the phase-shifted high window;
- the restart at A after a disable.

// File: rtl/pwm_chan_pkg.sv
// Shared types for the PWM channel generator.
// Assumes: mode bits are only sampled while the configuration is locked.
package pwm_chan_pkg;

    typedef enum logic [1:0] {
        MODE_PULSE = 2'd0,
        MODE_BLINK = 2'd1,
        MODE_BEAT  = 2'd2
    } pwm_mode_e;

    // Decode the two mode bits into a channel mode.
    function automatic pwm_mode_e pick_mode(input logic blink, input logic beat);
        if (!blink)
            return MODE_PULSE;
        else if (beat)
            return MODE_BEAT;
        else
            return MODE_BLINK;
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
// Phase counter with a clock pre-divider and a resolution-dependent step.
// Produces the phase, the compare mask for the active resolution and a
// one-cycle pulse on the tick that wraps the phase (end of a PWM period).
// Assumes: CNT_W is a power of two so resn covers 0..CNT_W-1 exactly.
module pwm_timebase #(
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 12,
    parameter int RESN_W = $clog2(CNT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DIV_W-1:0]  div,
    input  logic [RESN_W-1:0] resn,
    output logic [CNT_W-1:0]  phase,
    output logic [CNT_W-1:0]  cmp_mask,
    output logic              period_end
);
    logic [DIV_W-1:0]  div_cnt;
    logic [RESN_W-1:0] shamt;
    logic [CNT_W-1:0]  step;
    logic [CNT_W:0]    phase_sum;
    logic              tick;

    // Derive step size, mask, tick and wrap from the current settings.
    always_comb begin
        shamt      = RESN_W'(CNT_W - 1) - resn;
        step       = CNT_W'(1) << shamt;
        cmp_mask   = ~(step - CNT_W'(1));
        tick       = run && (div_cnt == div);
        phase_sum  = {1'b0, phase} + {1'b0, step};
        period_end = tick && phase_sum[CNT_W];
    end

    // Advance the divider and the phase; hold both at zero when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
            phase   <= '0;
        end else if (tick) begin
            div_cnt <= '0;
            phase   <= phase_sum[CNT_W-1:0];
        end else begin
            div_cnt <= div_cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/pwm_duty_seq.sv
// Duty-value sequencer: pulse, blink and heartbeat modes.
// Updates only on period boundaries so every period uses one duty value.
// Heartbeat steps saturate at the counter limits and clamp at the target.
// Assumes: configuration inputs are stable while en is high.
module pwm_duty_seq
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             period_end,
    input  pwm_mode_e        mode,
    input  logic [CNT_W-1:0] duty_a,
    input  logic [CNT_W-1:0] duty_b,
    input  logic [CNT_W-1:0] cnt_x,
    input  logic [CNT_W-1:0] cnt_y,
    output logic [CNT_W-1:0] duty_cur
);
    localparam int W1 = CNT_W + 1;

    logic [CNT_W-1:0] duty_q, hold_q, hold_lim, tgt, up_sat, dn_sat, beat_nxt;
    logic [W1-1:0]    inc, up_sum, dn_diff;
    logic             back_q, hold_last, beat_flip;

    assign duty_cur = duty_q;

    // Hold-length selection for the current segment.
    always_comb begin
        hold_lim  = (mode == MODE_BLINK && back_q) ? cnt_y : cnt_x;
        hold_last = (hold_q == hold_lim);
    end

    // Saturating heartbeat step toward the current target, with clamping.
    always_comb begin
        tgt       = back_q ? duty_a : duty_b;
        inc       = {1'b0, cnt_y} + W1'(1);
        up_sum    = {1'b0, duty_q} + inc;
        dn_diff   = {1'b0, duty_q} - inc;
        up_sat    = up_sum[CNT_W]  ? '1 : up_sum[CNT_W-1:0];
        dn_sat    = dn_diff[CNT_W] ? '0 : dn_diff[CNT_W-1:0];
        beat_nxt  = duty_q;
        beat_flip = 1'b0;
        if (duty_q < tgt) begin
            beat_nxt = up_sat;
            if (up_sat >= tgt) begin
                beat_nxt  = tgt;
                beat_flip = 1'b1;
            end
        end else if (duty_q > tgt) begin
            beat_nxt = dn_sat;
            if (dn_sat <= tgt) begin
                beat_nxt  = tgt;
                beat_flip = 1'b1;
            end
        end else begin
            beat_flip = 1'b1;
        end
    end

    // Sequence state: duty value, hold counter and segment direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            duty_q <= '0;
            hold_q <= '0;
            back_q <= 1'b0;
        end else if (!en || mode == MODE_PULSE) begin
            duty_q <= duty_a;
            hold_q <= '0;
            back_q <= 1'b0;
        end else if (period_end) begin
            if (!hold_last) begin
                hold_q <= hold_q + CNT_W'(1);
            end else begin
                hold_q <= '0;
                if (mode == MODE_BLINK) begin
                    duty_q <= back_q ? duty_a : duty_b;
                    back_q <= !back_q;
                end else begin
                    duty_q <= beat_nxt;
                    if (beat_flip)
                        back_q <= !back_q;
                end
            end
        end
    end
endmodule

// File: rtl/pwm_out_stage.sv
// Output stage: phase-offset compare against the duty at the active
// resolution, polarity inversion and the idle level, registered.
// Assumes: cmp_mask keeps only the top resn+1 bits.
module pwm_out_stage #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             invert,
    input  logic [CNT_W-1:0] phase,
    input  logic [CNT_W-1:0] phase_off,
    input  logic [CNT_W-1:0] cmp_mask,
    input  logic [CNT_W-1:0] duty,
    output logic             pwm_o
);
    logic [CNT_W-1:0] shifted;
    logic             raw_hi;

    // Compare the shifted phase with the duty over the kept bits.
    always_comb begin
        shifted = phase + phase_off;
        raw_hi  = (shifted & cmp_mask) < (duty & cmp_mask);
    end

    // Register the pin level; a disabled channel shows the idle level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_o <= 1'b0;
        else
            pwm_o <= en ? (raw_hi ^ invert) : invert;
    end
endmodule

// File: rtl/pwm_chan_gen.sv
// Top of the multi-mode PWM channel: holds the locked configuration and
// connects the timebase, duty sequencer and output stage.
// Assumes: cfg_* inputs are valid in the cycle cfg_wr is high.
module pwm_chan_gen
    import pwm_chan_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 12,
    parameter int RESN_W = $clog2(CNT_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cntr_en,
    input  logic              ch_en,
    input  logic              cfg_wr,
    input  logic [DIV_W-1:0]  cfg_clk_div,
    input  logic [RESN_W-1:0] cfg_resn,
    input  logic [CNT_W-1:0]  cfg_duty_a,
    input  logic [CNT_W-1:0]  cfg_duty_b,
    input  logic [CNT_W-1:0]  cfg_cnt_x,
    input  logic [CNT_W-1:0]  cfg_cnt_y,
    input  logic              cfg_blink,
    input  logic              cfg_beat,
    input  logic [CNT_W-1:0]  cfg_phase,
    input  logic              cfg_invert,
    output logic              pwm_o
);
    localparam int CFG_W = DIV_W + RESN_W + 5 * CNT_W + 3;

    logic [DIV_W-1:0]  div_q;
    logic [RESN_W-1:0] resn_q;
    logic [CNT_W-1:0]  duty_a_q, duty_b_q, cnt_x_q, cnt_y_q, phase_q;
    logic              blink_q, beat_q, invert_q;
    logic [CFG_W-1:0]  cfg_bus;
    logic [CNT_W-1:0]  phase, cmp_mask, duty_cur;
    logic              period_end, cfg_open;
    pwm_mode_e         mode;

    assign cfg_open = cfg_wr && !cntr_en && !ch_en;
    assign mode     = pick_mode(blink_q, beat_q);
    assign cfg_bus  = {div_q, resn_q, duty_a_q, duty_b_q, cnt_x_q, cnt_y_q,
                       phase_q, blink_q, beat_q, invert_q};

    // Configuration registers; writes land only while everything is stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= '0;
            resn_q   <= '0;
            duty_a_q <= '0;
            duty_b_q <= '0;
            cnt_x_q  <= '0;
            cnt_y_q  <= '0;
            phase_q  <= '0;
            blink_q  <= 1'b0;
            beat_q   <= 1'b0;
            invert_q <= 1'b0;
        end else if (cfg_open) begin
            div_q    <= cfg_clk_div;
            resn_q   <= cfg_resn;
            duty_a_q <= cfg_duty_a;
            duty_b_q <= cfg_duty_b;
            cnt_x_q  <= cfg_cnt_x;
            cnt_y_q  <= cfg_cnt_y;
            phase_q  <= cfg_phase;
            blink_q  <= cfg_blink;
            beat_q   <= cfg_beat;
            invert_q <= cfg_invert;
        end
    end

    pwm_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W), .RESN_W(RESN_W)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (cntr_en),
        .div        (div_q),
        .resn       (resn_q),
        .phase      (phase),
        .cmp_mask   (cmp_mask),
        .period_end (period_end)
    );

    pwm_duty_seq #(.CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ch_en),
        .period_end (period_end),
        .mode       (mode),
        .duty_a     (duty_a_q),
        .duty_b     (duty_b_q),
        .cnt_x      (cnt_x_q),
        .cnt_y      (cnt_y_q),
        .duty_cur   (duty_cur)
    );

    pwm_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ch_en),
        .invert    (invert_q),
        .phase     (phase),
        .phase_off (phase_q),
        .cmp_mask  (cmp_mask),
        .duty      (duty_cur),
        .pwm_o     (pwm_o)
    );
endmodule

// File: rtl/pwm_chan_chk.sv
// Assertion checker for pwm_chan_gen, attached with bind below.
// Assumes: the bench does not write the configuration in the cycle
// right before enabling the channel.
module pwm_chan_chk #(
    parameter int CNT_W = 16,
    parameter int CFG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cntr_en,
    input logic             ch_en,
    input logic [CFG_W-1:0] cfg_bus,
    input logic             blink_q,
    input logic             beat_q,
    input logic             invert_q,
    input logic [CNT_W-1:0] duty_a_q,
    input logic [CNT_W-1:0] duty_b_q,
    input logic [CNT_W-1:0] phase,
    input logic [CNT_W-1:0] duty_cur,
    input logic             pwm_o
);
    logic [CNT_W-1:0] lo_bound, hi_bound;

    // Heartbeat duty bounds: the smaller and larger of A and B.
    always_comb begin
        lo_bound = (duty_a_q < duty_b_q) ? duty_a_q : duty_b_q;
        hi_bound = (duty_a_q < duty_b_q) ? duty_b_q : duty_a_q;
    end

    p_cfg_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cntr_en || ch_en) |=> $stable(cfg_bus));

    p_phase_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cntr_en |=> (phase == '0));

    p_idle_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ch_en |=> (pwm_o == $past(invert_q)));

    p_pulse_duty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && $past(ch_en) && !blink_q) |-> (duty_cur == duty_a_q));

    p_blink_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && $past(ch_en) && blink_q && !beat_q)
            |-> (duty_cur == duty_a_q || duty_cur == duty_b_q));

    p_beat_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_en && $past(ch_en) && blink_q && beat_q)
            |-> (duty_cur >= lo_bound && duty_cur <= hi_bound));
endmodule

bind pwm_chan_gen pwm_chan_chk #(.CNT_W(CNT_W), .CFG_W(CFG_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cntr_en  (cntr_en),
    .ch_en    (ch_en),
    .cfg_bus  (cfg_bus),
    .blink_q  (blink_q),
    .beat_q   (beat_q),
    .invert_q (invert_q),
    .duty_a_q (duty_a_q),
    .duty_b_q (duty_b_q),
    .phase    (phase),
    .duty_cur (duty_cur),
    .pwm_o    (pwm_o)
);

// File: tb/tb_pwm_chan_gen.sv
// Directed bench for pwm_chan_gen: one task per scenario, per-period
// high counts compared with values worked out from the requirements.
module tb_pwm_chan_gen;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int DIV_W      = 12;
    localparam int RESN_W     = 4;
    localparam int WATCHDOG   = 200000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cntr_en = 1'b0, ch_en = 1'b0, cfg_wr = 1'b0;
    logic [DIV_W-1:0]  b_div = '0;
    logic [RESN_W-1:0] b_resn = '0;
    logic [CNT_W-1:0]  b_a = '0, b_b = '0, b_x = '0, b_y = '0, b_ph = '0;
    logic              b_blink = 1'b0, b_beat = 1'b0, b_inv = 1'b0;
    logic              pwm_o;

    int checks = 0;
    int fails  = 0;
    int hc[0:15];
    logic smp[0:63];

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_chan_gen #(.CNT_W(CNT_W), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst_n(rst_n), .cntr_en(cntr_en), .ch_en(ch_en),
        .cfg_wr(cfg_wr), .cfg_clk_div(b_div), .cfg_resn(b_resn),
        .cfg_duty_a(b_a), .cfg_duty_b(b_b), .cfg_cnt_x(b_x), .cfg_cnt_y(b_y),
        .cfg_blink(b_blink), .cfg_beat(b_beat), .cfg_phase(b_ph),
        .cfg_invert(b_inv), .pwm_o(pwm_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic stop_all();
        @(negedge clk);
        cntr_en = 1'b0;
        ch_en   = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load_cfg(input logic [CNT_W-1:0] a, input logic [CNT_W-1:0] b,
                            input logic [CNT_W-1:0] x, input logic [CNT_W-1:0] y,
                            input logic bl, input logic bt, input logic [CNT_W-1:0] ph,
                            input logic inv, input int dv, input int rs);
        @(negedge clk);
        b_a = a; b_b = b; b_x = x; b_y = y; b_blink = bl; b_beat = bt;
        b_ph = ph; b_inv = inv; b_div = DIV_W'(dv); b_resn = RESN_W'(rs);
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // Sample for nper periods of plen clocks without restarting.
    task automatic collect(input int nper, input int plen);
        for (int i = 0; i < 16; i++) hc[i] = 0;
        for (int i = 0; i < nper * plen; i++) begin
            @(negedge clk);
            if (i < 64) smp[i] = pwm_o;
            hc[i / plen] += int'(pwm_o);
        end
    endtask

    // Start counter and channel together, then sample aligned periods.
    task automatic start_collect(input int nper, input int plen);
        @(negedge clk);
        cntr_en = 1'b1;
        ch_en   = 1'b1;
        collect(nper, plen);
    endtask

    task automatic t_reset();
        chk("R1 pin after reset", int'(pwm_o), 0);
        // Counter stopped with a channel enabled on zeroed config: duty 0 gives low.
        @(negedge clk);
        ch_en = 1'b1;
        @(negedge clk);
        chk("R1 cleared duty gives low pin", int'(pwm_o), 0);
        stop_all();
    endtask

    task automatic t_pulse();
        load_cfg(16'h4000, 16'hC000, 0, 0, 0, 0, 0, 0, 0, 3);
        start_collect(3, 16);
        for (int p = 0; p < 3; p++) chk("R4 pulse uses A, R3 count", hc[p], 4);
        stop_all();
    endtask

    task automatic t_resolution();
        load_cfg(16'h8000, 0, 0, 0, 0, 0, 0, 0, 2, 1);
        start_collect(2, 12);
        chk("R2 div=2 resn=1 period 0", hc[0], 6);
        chk("R2 div=2 resn=1 period 1", hc[1], 6);
        chk("R2 phase step held 3 clocks", int'(smp[5]) * 10 + int'(smp[6]), 10);
        stop_all();
        load_cfg(16'hF000, 0, 0, 0, 0, 0, 0, 0, 0, 3);
        start_collect(2, 16);
        chk("R3 duty top bits 15", hc[0] + hc[1], 30);
        stop_all();
        // Counter held: phase stays 0, so duty 0xF000 keeps the pin high.
        @(negedge clk);
        ch_en = 1'b1;
        collect(1, 16);
        chk("R2 stopped counter holds phase zero", hc[0], 16);
        stop_all();
    endtask

    task automatic t_phase();
        load_cfg(16'h4000, 0, 0, 0, 0, 0, 16'h2000, 0, 0, 3);
        start_collect(2, 16);
        chk("R8 offset high at step 0", int'(smp[0]), 1);
        chk("R8 offset low at step 2", int'(smp[2]), 0);
        chk("R8 offset low at step 13", int'(smp[13]), 0);
        chk("R8 offset high at step 14", int'(smp[14]), 1);
        chk("R8 offset keeps count", hc[1], 4);
        stop_all();
    endtask

    task automatic t_invert();
        load_cfg(16'h4000, 0, 0, 0, 0, 0, 0, 1, 0, 3);
        start_collect(2, 16);
        chk("R9 inverted count", hc[1], 12);
        @(negedge clk);
        ch_en = 1'b0;
        collect(1, 8);
        chk("R10 idle level follows invert", hc[0], 8);
        stop_all();
    endtask

    task automatic t_lock();
        load_cfg(16'h4000, 0, 0, 0, 0, 0, 0, 0, 0, 3);
        start_collect(1, 16);
        @(negedge clk);
        b_a = 16'hC000;
        cfg_wr = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        collect(2, 16);
        chk("R11 write while running ignored", hc[0] + hc[1], 8);
        stop_all();
        @(negedge clk);
        cntr_en = 1'b1;
        cfg_wr  = 1'b1;
        @(negedge clk);
        cfg_wr  = 1'b0;
        stop_all();
        start_collect(1, 16);
        chk("R11 write with counter on ignored", hc[0], 4);
        stop_all();
    endtask

    task automatic t_blink();
        load_cfg(16'h4000, 16'hC000, 1, 0, 1, 0, 0, 0, 0, 3);
        start_collect(6, 16);
        chk("R5 A<B p0", hc[0], 4);  chk("R5 A<B p1", hc[1], 4);
        chk("R5 A<B p2", hc[2], 12); chk("R5 A<B p3", hc[3], 4);
        chk("R5 A<B p5", hc[5], 12);
        stop_all();
        load_cfg(16'hC000, 16'h2000, 0, 2, 1, 0, 0, 0, 0, 3);
        start_collect(5, 16);
        chk("R5 A>B p0", hc[0], 12); chk("R5 A>B p1", hc[1], 2);
        chk("R5 A>B p3", hc[3], 2);  chk("R5 A>B p4", hc[4], 12);
        stop_all();
        load_cfg(16'h6000, 16'h6000, 0, 0, 1, 0, 0, 0, 0, 3);
        start_collect(3, 16);
        chk("R5 A==B steady", hc[0] + hc[1] + hc[2], 18);
        stop_all();
    endtask

    task automatic t_beat();
        int up_exp[0:7];
        int dn_exp[0:7];
        up_exp = '{2, 3, 4, 5, 4, 3, 2, 3};
        dn_exp = '{5, 5, 4, 4, 3, 3, 4, 4};
        load_cfg(16'h2000, 16'h5000, 0, 16'h0FFF, 1, 1, 0, 0, 0, 3);
        start_collect(8, 16);
        for (int p = 0; p < 8; p++) chk("R6 ramp A<B", hc[p], up_exp[p]);
        stop_all();
        load_cfg(16'h5000, 16'h3000, 1, 16'h0FFF, 1, 1, 0, 0, 0, 3);
        start_collect(8, 16);
        for (int p = 0; p < 8; p++) chk("R6 ramp A>B hold 2", hc[p], dn_exp[p]);
        stop_all();
        load_cfg(16'hE000, 16'hFFFF, 0, 16'h7FFF, 1, 1, 0, 0, 0, 3);
        start_collect(4, 16);
        chk("R7 saturate high p0", hc[0], 14); chk("R7 saturate high p1", hc[1], 15);
        chk("R7 saturate high p2", hc[2], 14); chk("R7 saturate high p3", hc[3], 15);
        stop_all();
        load_cfg(16'h1000, 16'h0000, 0, 16'hFFFF, 1, 1, 0, 0, 0, 3);
        start_collect(4, 16);
        chk("R7 saturate low p1", hc[1], 0); chk("R7 saturate low p2", hc[2], 1);
        stop_all();
    endtask

    task automatic t_restart();
        load_cfg(16'h4000, 16'hC000, 0, 0, 1, 0, 0, 0, 0, 3);
        start_collect(2, 16);
        chk("R5 before disable p1", hc[1], 12);
        @(negedge clk);
        ch_en = 1'b0;
        collect(1, 20);
        chk("R10 disabled pin idle", hc[0], 0);
        stop_all();
        start_collect(2, 16);
        chk("R10 restart at A", hc[0], 4);
        chk("R10 restart then B", hc[1], 12);
        stop_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pulse();
        t_resolution();
        t_phase();
        t_invert();
        t_lock();
        t_blink();
        t_beat();
        t_restart();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule